// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Line Interrupts

This block is an eight-line general-purpose pin port. Software drives it over a small word-addressed register bus: a word address, a write strobe, a byte of write data and a registered byte of read data. Each line can be set as an input or an output. The block drives the pad output value and the pad output enable. Pad inputs pass through a two-flop synchroniser before anything else uses them.

The data register appears at every word of a 256-word window. The low eight bits of the word address form a per-line mask. A write changes only the lines whose mask bit is set. A read returns zero for every line whose mask bit is clear. Software can therefore update or sample any subset of lines in one access, with no read-modify-write.

Each line also has its own interrupt detector. It can watch a level or an edge, and an edge can be rising, falling or either one. Latched edge events stay set until software clears them. The raw and masked status can both be read back. All enabled events are ORed into one registered interrupt output. Eight read-only identification bytes sit at the top of the map.

Top module: `mmio_gpio`

## Requirements
- R1: After a synchronous reset, every configuration register, the data register, `pad_out`, `pad_oe`, `irq` and the raw status are all zero.
- R2: The direction register sits at byte offset 0x400 (word 0x100). A 1 in bit i makes line i an output. `pad_oe` equals the direction register, and `pad_out` equals the data register.
- R3: A write anywhere in byte offsets 0x000–0x3FC (word addresses 0x000–0x0FF) updates the data register bit i only when word-address bit i is 1. Bits whose address bit is 0 keep their value.
- R4: A read anywhere in the data window returns, for line i, the data-register bit if the line is an output and the synchronised pad input if it is an input. The result is ANDed with word-address bits [7:0]. `bus_rdata` holds the value for the address presented at the previous rising edge.
- R5: Sense (0x404), both-edges (0x408), event (0x40C) and enable (0x410) are read/write. With sense bit 0 and both-edges bit 0, event bit 1 latches a rising edge and event bit 0 latches a falling edge of the synchronised input into raw status (0x414).
- R6: With sense bit 0 and both-edges bit 1, either transition latches raw status, whatever the event bit says.
- R7: With sense bit 1, raw status follows the synchronised input level: high when the event bit is 1, low when it is 0. Writing the clear register does not change it.
- R8: Writing the clear register (0x41C) with bit i set clears line i's latched edge. Bits written as 0 leave their lines unchanged. When a new edge is detected in the same cycle as the clear, the edge wins and the status stays set.
- R9: Masked status (0x418) reads as raw status AND enable. `irq` is the OR of the masked status bits, registered one cycle later.
- R10: Byte offsets 0xFE0–0xFFC return the bytes 0x61, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in ascending address order.
- R11: Reads of unmapped offsets return 0. Writes to the status, identification or unmapped offsets change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wa | input | 10 | Word address (byte offset bits 11:2) |
| bus_we | input | 1 | Write strobe for the current word address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous address |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The two functions that can collide are the software clear of a line's latched edge and the hardware detection of a fresh edge on that same line. The bench changes a pad input and counts the two synchroniser edges. It then issues the clear write so that it lands on the exact edge where the detector reports the new transition. Raw status read afterwards must still show the line set. A later clear with no edge pending must then drop it.

// File: rtl/mmio_gpio_pkg.sv
package mmio_gpio_pkg;

  localparam int WA_W   = 10;
  localparam int BYTE_W = 8;

  localparam logic [WA_W-1:0] WA_DIR   = 10'h100;
  localparam logic [WA_W-1:0] WA_SENSE = 10'h101;
  localparam logic [WA_W-1:0] WA_BOTH  = 10'h102;
  localparam logic [WA_W-1:0] WA_POLAR = 10'h103;
  localparam logic [WA_W-1:0] WA_IE    = 10'h104;
  localparam logic [WA_W-1:0] WA_RAW   = 10'h105;
  localparam logic [WA_W-1:0] WA_MSK   = 10'h106;
  localparam logic [WA_W-1:0] WA_CLR   = 10'h107;

  function automatic logic in_data_win(input logic [WA_W-1:0] wa);
    return wa[WA_W-1:8] == '0;
  endfunction

  function automatic logic in_id_win(input logic [WA_W-1:0] wa);
    return wa[WA_W-1:3] == '1;
  endfunction

  function automatic logic [BYTE_W-1:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h61;
      3'd1: return 8'h10;
      3'd2: return 8'h04;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d;
  end

  for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[gs] <= '0;
      else     stage_q[gs] <= stage_q[gs-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_in,
  input  logic [N-1:0] sense,
  input  logic [N-1:0] both,
  input  logic [N-1:0] polar,
  input  logic [N-1:0] clr,
  output logic [N-1:0] raw
);

  logic [N-1:0] prev_q;
  logic [N-1:0] latch_q;
  logic [N-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl_in;
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_line
    logic rise, fall;
    assign rise    = lvl_in[gi] & ~prev_q[gi];
    assign fall    = ~lvl_in[gi] & prev_q[gi];
    assign hit[gi] = ~sense[gi] & (both[gi] ? (rise | fall) : (polar[gi] ? rise : fall));

    always_ff @(posedge clk) begin
      if (rst)          latch_q[gi] <= 1'b0;
      else if (hit[gi]) latch_q[gi] <= 1'b1;
      else if (clr[gi]) latch_q[gi] <= 1'b0;
    end

    assign raw[gi] = sense[gi] ? (polar[gi] ? lvl_in[gi] : ~lvl_in[gi]) : latch_q[gi];

    p_edge_sets_r5: assert property (@(posedge clk) disable iff (rst)
      hit[gi] |=> latch_q[gi]) else $error("edge not latched line %0d", gi);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (latch_q[gi] && !clr[gi]) |=> latch_q[gi]) else $error("latched edge lost line %0d", gi);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
      (clr[gi] && !hit[gi]) |=> !latch_q[gi]) else $error("clear ignored line %0d", gi);
  end

endmodule

// File: rtl/gpio_rdmux.sv
module gpio_rdmux
  import mmio_gpio_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [WA_W-1:0]   wa,
  input  logic [N-1:0]      dir,
  input  logic [N-1:0]      data,
  input  logic [N-1:0]      pins,
  input  logic [N-1:0]      sense,
  input  logic [N-1:0]      both,
  input  logic [N-1:0]      polar,
  input  logic [N-1:0]      ie,
  input  logic [N-1:0]      raw,
  output logic [BYTE_W-1:0] rd
);

  logic [N-1:0] line_val;
  logic [N-1:0] sel;

  assign sel      = wa[N-1:0];
  assign line_val = ((dir & data) | (~dir & pins)) & sel;

  always_comb begin
    rd = '0;
    if (in_data_win(wa)) begin
      rd[N-1:0] = line_val;
    end else if (in_id_win(wa)) begin
      rd = id_byte(wa[2:0]);
    end else begin
      case (wa)
        WA_DIR:   rd[N-1:0] = dir;
        WA_SENSE: rd[N-1:0] = sense;
        WA_BOTH:  rd[N-1:0] = both;
        WA_POLAR: rd[N-1:0] = polar;
        WA_IE:    rd[N-1:0] = ie;
        WA_RAW:   rd[N-1:0] = raw;
        WA_MSK:   rd[N-1:0] = raw & ie;
        default:  rd = '0;
      endcase
    end
  end

endmodule

// File: rtl/mmio_gpio.sv
module mmio_gpio
  import mmio_gpio_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WA_W-1:0]    bus_wa,
  input  logic               bus_we,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [BYTE_W-1:0]  bus_rdata,
  input  logic [N_LINES-1:0] pad_in,
  output logic [N_LINES-1:0] pad_out,
  output logic [N_LINES-1:0] pad_oe,
  output logic               irq
);

  logic [N_LINES-1:0] dir_q, data_q, sense_q, both_q, polar_q, ie_q;
  logic [N_LINES-1:0] pins_s, raw, masked, clr, wmask, wval;
  logic [BYTE_W-1:0]  rd_next, rdata_q;
  logic               irq_q;
  logic               wr_data, unmapped;

  assign wmask   = bus_wa[N_LINES-1:0];
  assign wval    = bus_wdata[N_LINES-1:0];
  assign wr_data = bus_we && in_data_win(bus_wa);
  assign clr     = (bus_we && bus_wa == WA_CLR) ? wval : '0;
  assign masked  = raw & ie_q;
  assign unmapped = !in_data_win(bus_wa) && !in_id_win(bus_wa) &&
                    (bus_wa < WA_DIR || bus_wa > WA_CLR);

  gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pins_s)
  );

  gpio_irq_detect #(.N(N_LINES)) u_detect (
    .clk(clk), .rst(rst), .lvl_in(pins_s), .sense(sense_q), .both(both_q),
    .polar(polar_q), .clr(clr), .raw(raw)
  );

  gpio_rdmux #(.N(N_LINES)) u_rdmux (
    .wa(bus_wa), .dir(dir_q), .data(data_q), .pins(pins_s), .sense(sense_q),
    .both(both_q), .polar(polar_q), .ie(ie_q), .raw(raw), .rd(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      data_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
      polar_q <= '0;
      ie_q    <= '0;
    end else if (bus_we) begin
      if (wr_data) begin
        data_q <= (data_q & ~wmask) | (wval & wmask);
      end else begin
        case (bus_wa)
          WA_DIR:   dir_q   <= wval;
          WA_SENSE: sense_q <= wval;
          WA_BOTH:  both_q  <= wval;
          WA_POLAR: polar_q <= wval;
          WA_IE:    ie_q    <= wval;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_next;
      irq_q   <= |masked;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign pad_out   = data_q;
  assign pad_oe    = dir_q;

  for (genvar gl = 0; gl < N_LINES; gl++) begin : g_chk
    p_masked_wr_r3: assert property (@(posedge clk) disable iff (rst)
      (bus_we && in_data_win(bus_wa) && !bus_wa[gl]) |=> $stable(pad_out[gl]))
      else $error("masked line %0d changed", gl);
  end

  p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
    (|masked) |=> irq) else $error("irq missing");
  p_irq_clr_r9: assert property (@(posedge clk) disable iff (rst)
    !(|masked) |=> !irq) else $error("irq spurious");
  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> bus_rdata == '0) else $error("unmapped read nonzero");
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && !irq)) else $error("reset state");

endmodule

// File: tb/mmio_gpio_tb_top.sv
`timescale 1ns/1ps
module mmio_gpio_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic [9:0] bus_wa;
  logic       bus_we;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_out;
  logic [7:0] pad_oe;
  logic       irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mmio_gpio dut_i (
    .clk(clk), .rst(rst), .bus_wa(bus_wa), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  localparam logic [9:0] A_DIR = 10'h100, A_SEN = 10'h101, A_BTH = 10'h102,
                         A_POL = 10'h103, A_IE  = 10'h104, A_RAW = 10'h105,
                         A_MSK = 10'h106, A_CLR = 10'h107;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wa = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_wa = a; bus_we = 1'b0;
    @(posedge clk);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(A_DIR, v);  chk("R1 dir", v, 8'h00);
    rd(A_RAW, v);  chk("R1 raw", v, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_masked_data();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    chk("R2 pad_oe", pad_oe, 8'hFF);
    wr(10'h00F, 8'hAA);
    chk("R3 low nibble", pad_out, 8'h0A);
    wr(10'h0F0, 8'h55);
    chk("R3 high nibble", pad_out, 8'h5A);
    wr(10'h000, 8'hFF);
    chk("R3 empty mask", pad_out, 8'h5A);
    rd(10'h03C, v); chk("R4 masked read", v, 8'h18);
  endtask

  task automatic t_input_read();
    logic [7:0] v;
    wr(A_DIR, 8'h0F);
    chk("R2 pad_oe mixed", pad_oe, 8'h0F);
    @(negedge clk) pad_in = 8'hC3;
    settle();
    rd(10'h0FF, v); chk("R4 mixed read", v, 8'hCA);
    rd(10'h081, v); chk("R4 partial read", v, 8'h80);
    wr(A_DIR, 8'h00);
    @(negedge clk) pad_in = 8'h00;
    settle();
    wr(A_CLR, 8'hFF);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    wr(A_SEN, 8'h00); wr(A_BTH, 8'h00); wr(A_POL, 8'h01); wr(A_IE, 8'hFF);
    rd(A_SEN, v); chk("R5 sense rw", v, 8'h00);
    rd(A_POL, v); chk("R5 event rw", v, 8'h01);
    rd(A_RAW, v); chk("R5 raw idle", v, 8'h00);
    @(negedge clk) pad_in = 8'h03;
    settle();
    rd(A_RAW, v); chk("R5 rising only line0", v, 8'h01);
    @(negedge clk) pad_in = 8'h00;
    settle();
    rd(A_RAW, v); chk("R5 falling line1", v, 8'h03);
    chk("R9 irq high", {7'd0, irq}, 8'h01);
    wr(A_IE, 8'h02);
    rd(A_MSK, v); chk("R9 masked", v, 8'h02);
    wr(A_CLR, 8'h01);
    rd(A_RAW, v); chk("R8 clear bit0 only", v, 8'h02);
    wr(A_CLR, 8'h02);
    settle();
    rd(A_RAW, v); chk("R8 cleared", v, 8'h00);
    chk("R9 irq low", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_both();
    logic [7:0] v;
    wr(A_BTH, 8'h04); wr(A_POL, 8'h04);
    @(negedge clk) pad_in = 8'h04;
    settle();
    rd(A_RAW, v); chk("R6 rise", v, 8'h04);
    wr(A_CLR, 8'h04);
    @(negedge clk) pad_in = 8'h00;
    settle();
    rd(A_RAW, v); chk("R6 fall despite event", v, 8'h04);
    wr(A_CLR, 8'hFF); wr(A_BTH, 8'h00); wr(A_POL, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] v;
    wr(A_POL, 8'h10); wr(A_SEN, 8'h10);
    @(negedge clk) pad_in = 8'h10;
    settle();
    rd(A_RAW, v); chk("R7 level high", v, 8'h10);
    wr(A_CLR, 8'h10);
    rd(A_RAW, v); chk("R7 clear no effect", v, 8'h10);
    @(negedge clk) pad_in = 8'h00;
    settle();
    rd(A_RAW, v); chk("R7 level follows", v, 8'h00);
    wr(A_SEN, 8'h00); wr(A_POL, 8'h00);
    rd(A_RAW, v); chk("R7 no stale latch", v, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(A_POL, 8'h20);
    @(negedge clk) pad_in = 8'h20;
    @(posedge clk);
    @(posedge clk);
    wr(A_CLR, 8'h20);
    rd(A_RAW, v); chk("R8 edge beats clear", v, 8'h20);
    wr(A_CLR, 8'h20);
    rd(A_RAW, v); chk("R8 later clear", v, 8'h00);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    logic [7:0] exp_id [8] = '{8'h61, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int k = 0; k < 8; k++) begin
      rd(10'h3F8 + 10'(k), v); chk("R10 id byte", v, exp_id[k]);
    end
    wr(10'h3F8, 8'h00);
    rd(10'h3F8, v); chk("R11 id write ignored", v, 8'h61);
    wr(A_RAW, 8'hFF);
    rd(A_RAW, v); chk("R11 raw write ignored", v, 8'h00);
    wr(10'h200, 8'hFF);
    rd(10'h200, v); chk("R11 unmapped read", v, 8'h00);
    rd(10'h108, v); chk("R11 unmapped ctl", v, 8'h00);
    rd(A_CLR, v); chk("R11 clear reads zero", v, 8'h00);
    chk("R11 pads unchanged", pad_out, 8'h5A);
  endtask

  initial begin
    rst = 1'b1; bus_wa = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_masked_data();
    t_input_read();
    t_edges();
    t_both();
    t_level();
    t_collision();
    t_ident();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule